// File: doc/BRIEF.md
# Three-wire serial EEPROM device model with self-timed programming

This block is the device side of a small serial EEPROM holding 256 words of 16 bits. A host drives a select line, a serial clock and a data line. The block samples all of them on a much faster system clock and answers on a data-out line that has its own output-enable. Instructions are framed by the select line. Each one starts with a 1 bit and carries a two-bit opcode and an 8-bit address, both sent most significant bit first. Data words follow where the opcode needs them. The instructions read a word, write a word, write every word, and set or clear a write-enable latch.

Reads start with a single 0 bit and then shift the addressed word out, most significant bit first. If the host keeps clocking, the next words follow in order and the address wraps from the top word to word 0. A write takes effect only when the host drops select right after the last data bit, and only when the write-enable latch is set and the program-enable pin is high. Programming then runs for a fixed number of system clocks. While select is high after a programming start, the data-out line shows 0 while busy and 1 once ready. Storage is a register array that is cleared by reset.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Zero bits clocked in while idle are ignored, and the first 1 is taken as the start bit, so a lead-in such as 0,0,1 begins an instruction.
- R2: After the start bit, the block decodes the opcode bits, then 8 address bits, most significant bit first. The opcodes are 10 = read, 01 = write, and 00 = special. For the special opcode, the top two address bits select the action: 11 = enable writes, 00 = disable writes, 01 = write all words. The remaining address bits are ignored.
- R3: On a read, data-out is driven with a 0 from the serial clock rising edge that carries the last address bit. Each later rising edge puts out the next bit of the word, most significant bit first. Data-out does not change between rising edges.
- R4: A read clocked past the last bit of a word continues with the word at the next address, and address 255 is followed by address 0.
- R5: The write-enable latch is clear after reset. While it is clear, writes and write-all change nothing. The enable command sets it, the disable command clears it, and reads work in either state.
- R6: Programming starts only on the fall of select that directly follows the 16th data bit. An extra serial clock rising edge before select falls cancels the write.
- R7: While select is high after a programming start, data-out is enabled and reads 0 while busy and 1 once ready. The 1 stays until the next start bit, which turns the output-enable off.
- R8: The output-enable is off whenever select is low.
- R9: Instructions received while programming is busy have no effect.
- R10: With program-enable low, write, write-all, enable and disable have no effect.
- R11: Select going low in the middle of an instruction discards it, and the next instruction decodes normally.
- R12: Write-all stores its data word in every address.
- R13: Every word reads 0 after reset. A programmed word is committed once PROG_CYCLES system clocks have passed since the programming start, and ready appears at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset (power up) |
| cs | input | 1 | Select, active high, frames each instruction |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data in |
| pe | input | 1 | Program-enable; must be high for writes and latch commands |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Output-enable for do_o; when low the pin is high-impedance |

## Verification
The hardest condition to reach from the ports is an instruction that arrives while programming is busy. The stimulus starts a write, raises select again at once, and clocks a complete second write within the busy window. It then checks that data-out still reads busy during that instruction and that the second address keeps its old value. Cancelling a write with a single extra serial clock is also hard to provoke. That case is checked by the absence of any busy indication when select rises next, and again by reading the word back.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_WDONE,
    ST_READ,
    ST_DROP
  } mw_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_READ,
    CMD_WRITE,
    CMD_EWEN,
    CMD_EWDS,
    CMD_WRAL
  } mw_cmd_e;

  // opcode then the two leading address bits select the action
  function automatic mw_cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] sel);
    mw_cmd_e c;
    c = CMD_NONE;
    case (opc)
      2'b10: c = CMD_READ;
      2'b01: c = CMD_WRITE;
      2'b00: begin
        case (sel)
          2'b11:   c = CMD_EWEN;
          2'b00:   c = CMD_EWDS;
          2'b01:   c = CMD_WRAL;
          default: c = CMD_NONE;
        endcase
      end
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic pe,
  output logic cs_s,
  output logic di_s,
  output logic pe_s,
  output logic sk_rise,
  output logic cs_fall
);
  localparam int PINS = 4;

  logic [PINS-1:0] pipe [STAGES];
  logic            cs_q;
  logic            sk_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= {cs, sk, di, pe};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign cs_s = pipe[STAGES-1][3];
  assign di_s = pipe[STAGES-1][1];
  assign pe_s = pipe[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs_s;
      sk_q <= pipe[STAGES-1][2];
    end
  end

  assign sk_rise = pipe[STAGES-1][2] & ~sk_q;
  assign cs_fall = cs_q & ~cs_s;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= W'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == W'(1));
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_all,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (wr_en && (wr_all || (wr_addr == ADDR_W'(g))))
        mem[g] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mw_serial_ctrl.sv
module mw_serial_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              di_s,
  input  logic              pe_s,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DATA_W-1:0] pend_data,
  output logic              pend_all,
  output logic              prog_start,
  output logic              ewen_evt,
  output logic              ewds_evt,
  output logic              wel,
  output logic              rd_active,
  output logic              status_on,
  output logic              dout
);
  localparam int CNT_MAX = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(1);

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  mw_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;
  logic              is_wral;
  logic              stat_flag;

  logic              edge_ok;
  logic [ADDR_W-1:0] full_addr;
  mw_cmd_e           cmd;
  logic              addr_last;

  assign edge_ok    = cs_s & sk_rise;
  assign full_addr  = {addr_sh[ADDR_W-2:0], di_s};
  assign cmd        = decode_cmd(opc, full_addr[ADDR_W-1 -: 2]);
  assign addr_last  = (state == ST_ADDR) && edge_ok && (cnt == ADDR_LAST);
  assign ewen_evt   = addr_last && (cmd == CMD_EWEN) && pe_s;
  assign ewds_evt   = addr_last && (cmd == CMD_EWDS) && pe_s;
  assign prog_start = (state == ST_WDONE) && cs_fall && wel && pe_s && !busy;
  assign rd_active  = (state == ST_READ);
  assign status_on  = (state == ST_IDLE) && stat_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      opc       <= '0;
      addr_sh   <= '0;
      data_sh   <= '0;
      is_wral   <= 1'b0;
      stat_flag <= 1'b0;
      wel       <= 1'b0;
      rd_ptr    <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_all  <= 1'b0;
      dout      <= 1'b0;
    end else begin
      if (ewen_evt)      wel <= 1'b1;
      else if (ewds_evt) wel <= 1'b0;

      if (!cs_s) begin
        state <= ST_IDLE;
        cnt   <= '0;
        if (prog_start) begin
          pend_addr <= addr_sh;
          pend_data <= data_sh;
          pend_all  <= is_wral;
          stat_flag <= 1'b1;
        end
      end else if (edge_ok) begin
        case (state)
          ST_IDLE: begin
            if (di_s && !busy) begin
              state     <= ST_OPC;
              cnt       <= '0;
              stat_flag <= 1'b0;
            end
          end
          ST_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == OPC_LAST) begin
              cnt   <= '0;
              state <= ST_ADDR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_sh <= full_addr;
            if (addr_last) begin
              cnt     <= '0;
              is_wral <= (cmd == CMD_WRAL);
              case (cmd)
                CMD_READ: begin
                  state  <= ST_READ;
                  rd_ptr <= full_addr;
                  dout   <= 1'b0;
                end
                CMD_WRITE, CMD_WRAL: state <= ST_WDATA;
                default:             state <= ST_DROP;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WDATA: begin
            data_sh <= {data_sh[DATA_W-2:0], di_s};
            if (cnt == DATA_LAST) state <= ST_WDONE;
            else                  cnt   <= cnt + 1'b1;
          end
          ST_WDONE: state <= ST_DROP;
          ST_READ: begin
            dout <= rd_data[DATA_LAST - cnt];
            if (cnt == DATA_LAST) begin
              cnt    <= '0;
              rd_ptr <= addr_inc(rd_ptr);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic pe,
  output logic do_o,
  output logic do_oe
);
  logic              cs_s, di_s, pe_s, sk_rise, cs_fall;
  logic              busy, prog_done, prog_start;
  logic              ewen_evt, ewds_evt, wel, rd_active, status_on, dout;
  logic              pend_all;
  logic [ADDR_W-1:0] rd_ptr, pend_addr;
  logic [DATA_W-1:0] pend_data, rd_data;

  mw_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pe(pe),
    .cs_s(cs_s), .di_s(di_s), .pe_s(pe_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_serial_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s), .pe_s(pe_s),
    .sk_rise(sk_rise), .cs_fall(cs_fall), .busy(busy), .rd_data(rd_data),
    .rd_ptr(rd_ptr), .pend_addr(pend_addr), .pend_data(pend_data),
    .pend_all(pend_all), .prog_start(prog_start), .ewen_evt(ewen_evt),
    .ewds_evt(ewds_evt), .wel(wel), .rd_active(rd_active),
    .status_on(status_on), .dout(dout)
  );

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(prog_done)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_done), .wr_all(pend_all),
    .wr_addr(pend_addr), .wr_data(pend_data), .rd_addr(rd_ptr), .rd_data(rd_data)
  );

  assign do_oe = cs_s && (rd_active || status_on);
  assign do_o  = rd_active ? dout : ~busy;
endmodule

// File: rtl/mw_eeprom_checker.sv
module mw_eeprom_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic pe_s,
  input logic sk_rise,
  input logic do_o,
  input logic do_oe,
  input logic wel,
  input logic ewen_evt,
  input logic ewds_evt,
  input logic prog_start,
  input logic busy,
  input logic rd_active
);
  a_r8_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !do_oe);

  a_r5_wel_set_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(ewen_evt));

  a_r5_wel_clr_by_disable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(ewds_evt));

  a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);

  a_r10_start_needs_pe_wel: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> (pe_s && wel));

  a_r13_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  a_r3_read_bit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && $past(rd_active) && !$past(sk_rise)) |-> $stable(do_o));
endmodule

bind mw_eeprom_slave mw_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .pe_s(pe_s), .sk_rise(sk_rise),
  .do_o(do_o), .do_oe(do_oe), .wel(wel), .ewen_evt(ewen_evt),
  .ewds_evt(ewds_evt), .prog_start(prog_start), .busy(busy),
  .rd_active(rd_active)
);

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_T     = 1500;
  localparam int WD_CYCLES  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, pe = 1'b1;
  logic do_o, do_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_slave #(.PROG_CYCLES(PROG_T)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .pe(pe),
    .do_o(do_o), .do_oe(do_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one serial bit: 16 system clocks, sampled late in the high phase
  task automatic bit_io(input logic b, output logic sd, output logic so);
    di = b;
    repeat (8) @(negedge clk);
    sk = 1'b1;
    repeat (7) @(negedge clk);
    sd = do_o;
    so = do_oe;
    @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic sd, so;
    for (int i = n - 1; i >= 0; i--) bit_io(v[i], sd, so);
  endtask

  task automatic cs_up();
    cs = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_dn();
    sk = 1'b0;
    cs = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr_cmd(input logic [2:0] hdr, input logic [7:0] a,
                        input logic [15:0] d, input bit extra);
    cs_up();
    send(32'(hdr), 3);
    send(32'(a), 8);
    send(32'(d), 16);
    if (extra) send(32'd0, 1);
    cs_dn();
  endtask

  task automatic latch_cmd(input logic [7:0] a);
    cs_up();
    send(32'b100, 3);
    send(32'(a), 8);
    cs_dn();
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (do_o !== 1'b1 && cyc < 3 * PROG_T) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // after a write attempt: raise select and check for busy/ready or its absence
  task automatic status_after(input bit expect_prog, input string tag);
    int cyc;
    cs_up();
    if (!expect_prog) begin
      chk({tag, " no programming started"}, 32'(do_oe), 32'd0);
    end else begin
      chk({tag, " R7 busy shown"}, 32'({do_oe, do_o}), 32'b10);
      wait_ready(cyc);
      chk({tag, " R7 ready shown"}, 32'({do_oe, do_o}), 32'b11);
      chk({tag, " R13 programming time"},
          32'((cyc >= PROG_T - 40) && (cyc <= PROG_T)), 32'd1);
    end
    cs_dn();
  endtask

  task automatic rd_check(input logic [7:0] a, input int nw, input string tag);
    logic sd, so;
    logic [15:0] got;
    logic oe_all;
    cs_up();
    send(32'b110, 3);
    send(32'(a >> 1), 7);
    bit_io(a[0], sd, so);
    chk({tag, " R3 dummy zero"}, 32'({so, sd}), 32'b10);
    for (int w = 0; w < nw; w++) begin
      oe_all = 1'b1;
      for (int b = 15; b >= 0; b--) begin
        bit_io(1'b0, sd, so);
        got[b] = sd;
        oe_all = oe_all & so;
      end
      chk({tag, " R3 read word"}, 32'(got), 32'(model[8'(a + 8'(w))]));
      chk({tag, " R3 output enabled"}, 32'(oe_all), 32'd1);
    end
    cs_dn();
  endtask

  task automatic t_reset();
    chk("R8 oe low while deselected at reset", 32'(do_oe), 32'd0);
    rd_check(8'h05, 1, "R13 reset contents");
    wr_cmd(3'b101, 8'h05, 16'h1234, 1'b0);
    status_after(1'b0, "R5 write with latch clear");
    rd_check(8'h05, 1, "R5 write ignored");
  endtask

  task automatic t_enable_write();
    logic sd, so;
    int cyc;
    latch_cmd(8'hC0);
    wr_cmd(3'b101, 8'h05, 16'hA5C3, 1'b0);
    model[8'h05] = 16'hA5C3;
    cs_up();
    chk("R7 busy after R2 write decode", 32'({do_oe, do_o}), 32'b10);
    wait_ready(cyc);
    chk("R7 ready reached", 32'({do_oe, do_o}), 32'b11);
    bit_io(1'b0, sd, so);
    chk("R7 ready persists over zero bit", 32'({so, sd}), 32'b11);
    bit_io(1'b1, sd, so);
    chk("R7 start bit removes status", 32'(so), 32'd0);
    cs_dn();
    chk("R8 oe low after select drop", 32'(do_oe), 32'd0);
    rd_check(8'h05, 1, "R6 committed write");
  endtask

  task automatic t_wrap();
    wr_cmd(3'b101, 8'hFF, 16'hBEEF, 1'b0);
    model[8'hFF] = 16'hBEEF;
    status_after(1'b1, "R4 top word");
    wr_cmd(3'b101, 8'h00, 16'h1357, 1'b0);
    model[8'h00] = 16'h1357;
    status_after(1'b1, "R4 word zero");
    rd_check(8'hFF, 3, "R4 wrap read");
  endtask

  task automatic t_lead_zero();
    logic sd, so;
    logic [15:0] got;
    cs_up();
    send(32'b00110, 5);
    send(32'h02, 7);
    bit_io(1'b1, sd, so);
    chk("R1 dummy after lead-in zeros", 32'({so, sd}), 32'b10);
    for (int b = 15; b >= 0; b--) begin
      bit_io(1'b0, sd, so);
      got[b] = sd;
    end
    chk("R1 read after lead-in zeros", 32'(got), 32'(model[8'h05]));
    cs_dn();
  endtask

  task automatic t_extra_clock();
    wr_cmd(3'b101, 8'h10, 16'hFACE, 1'b1);
    status_after(1'b0, "R6 extra clock");
    rd_check(8'h10, 1, "R6 cancelled write");
  endtask

  task automatic t_cs_abort();
    cs_up();
    send(32'b110010, 6);
    cs_dn();
    rd_check(8'h05, 1, "R11 after aborted instruction");
  endtask

  task automatic t_busy_ignore();
    logic sd, so;
    int cyc;
    wr_cmd(3'b101, 8'h20, 16'h1111, 1'b0);
    model[8'h20] = 16'h1111;
    cs_up();
    bit_io(1'b1, sd, so);
    chk("R9 busy seen at ignored start", 32'({so, sd}), 32'b10);
    send(32'b01, 2);
    send(32'h21, 8);
    send(32'h2222, 16);
    chk("R9 still busy after ignored write", 32'({do_oe, do_o}), 32'b10);
    cs_dn();
    cs_up();
    wait_ready(cyc);
    chk("R9 ready after first write", 32'({do_oe, do_o}), 32'b11);
    cs_dn();
    rd_check(8'h20, 2, "R9 busy-time write ignored");
  endtask

  task automatic t_pe_low();
    pe = 1'b0;
    latch_cmd(8'h00);
    wr_cmd(3'b101, 8'h30, 16'hDEAD, 1'b0);
    status_after(1'b0, "R10 write with pe low");
    pe = 1'b1;
    wr_cmd(3'b101, 8'h31, 16'hC0DE, 1'b0);
    model[8'h31] = 16'hC0DE;
    status_after(1'b1, "R10 disable with pe low ignored");
    rd_check(8'h30, 2, "R10 pe low contents");
  endtask

  task automatic t_disable();
    latch_cmd(8'h00);
    wr_cmd(3'b101, 8'h40, 16'h4444, 1'b0);
    status_after(1'b0, "R5 write after disable");
    rd_check(8'h40, 1, "R5 read with latch clear");
  endtask

  task automatic t_write_all();
    latch_cmd(8'hC0);
    wr_cmd(3'b100, 8'h40, 16'h5A5A, 1'b0);
    for (int i = 0; i < 256; i++) model[i] = 16'h5A5A;
    status_after(1'b1, "R12 write-all");
    rd_check(8'hFF, 2, "R12 all words top");
    rd_check(8'h77, 1, "R12 all words middle");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'h0000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_enable_write();
    t_wrap();
    t_lead_zero();
    t_extra_clock();
    t_cs_abort();
    t_busy_ignore();
    t_pe_low();
    t_disable();
    t_write_all();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule